// File: doc/BRIEF.md
# Transmit Sample Queue with Underrun Repeat

This block sits on the transmit side of a serial audio or modem link controller. A memory-side writer pushes fixed-width samples into a small first-in first-out store, and a slot-timed consumer asks for one sample per frame. Each request takes the oldest stored sample and shows it on a registered output. If the consumer asks while the store is empty, the block does not move either pointer. It keeps driving the last sample it handed out and records the event in a sticky error flag.

A two-word register interface lets software see and manage the error. The status word holds the sticky flag, which is cleared by writing a one to its bit. The control word holds an enable bit that gates the flag onto a level-sensitive interrupt line. Software has access to nothing else. The asynchronous active-low reset is synchronised inside the block before it is used.

Top module: `txf_underrun_fifo`

## Requirements
- R1: After reset both register words read 0x0000_0000, `sample_out` is zero, `fifo_empty` is 1, `fifo_full` is 0 and `irq` is 0.
- R2: Samples come out in the order they were accepted. A request made with data present updates `sample_out` at the clock edge that samples the request.
- R3: `fifo_full` is 1 when DEPTH samples are held. A push while full is dropped, so after the excess pushes only the first DEPTH samples are returned, followed by an underrun.
- R4: A request while the store is empty sets the status error flag (bit 4, `reg_sel`=1) at that clock edge.
- R5: On every underrun request `sample_out` keeps the last sample actually popped. If nothing has been popped since reset, it stays zero.
- R6: An underrun moves neither pointer. A sample pushed after an underrun is the one returned by the next request, and the error flag stays set.
- R7: A status write with bit 4 = 1 clears the flag. A status write with bit 4 = 0 leaves it as it was.
- R8: When an underrun and a clearing status write fall in the same cycle, the flag ends up 1.
- R9: The control word (`reg_sel`=0) stores only the interrupt enable at bit 3. Every other control bit reads zero whatever was written.
- R10: `irq` is 1 exactly while the enable bit and the error flag are both 1. It falls when software clears the flag.
- R11: The status word reads zero in every bit except bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Writer offers a sample this cycle |
| push_data | input | WIDTH | Sample offered by the writer |
| fifo_full | output | 1 | Store holds DEPTH samples; pushes are dropped |
| fifo_empty | output | 1 | Store holds no sample |
| pop_req | input | 1 | Consumer asks for the next sample |
| sample_out | output | WIDTH | Last sample handed out |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 the status word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level error interrupt |

## Verification
The bench sweeps every fill level from one sample up to full. At each level it drains the store and then asks once more. A design that advanced a pointer on the empty request would return stale memory on the next sweep instead of the freshly pushed first sample. A design that cleared the output would show zero where the last sample should repeat. It also overfills the store to catch a design that overwrites the oldest entry when full, and checks the zero repeat value before anything was ever popped. It drives an underrun and a clearing write in the same cycle, where a design that let the clear win would drop the flag. Finally it writes all-ones and all-zeros patterns to both words, which exposes stray writable bits, a clear on write-zero, or an interrupt that ignores its enable.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned IRQ_EN_BIT   = 3;
  localparam int unsigned ERR_FLAG_BIT = 4;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/txf_ptr_ctrl.sv
module txf_ptr_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          underrun_evt,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          empty
);

  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] rd_q, rd_d;
  logic [PW-1:0] fill;

  // Pointer-derived flags: equal pointers mean empty, equal index with
  // opposite wrap bits means full.
  always_comb begin
    empty        = (wr_q == rd_q);
    full         = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
    push_ok      = push_valid && !full;
    pop_ok       = pop_req && !empty;
    underrun_evt = pop_req && empty;
    fill         = wr_q - rd_q;
  end

  // Next-state: pointers only move on accepted operations.
  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push_ok) wr_d = wr_q + PW'(1);
    if (pop_ok)  rd_d = rd_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_d;
      if (pop_ok)  rd_q <= rd_d;
    end
  end

  assign wr_addr = wr_q[AW-1:0];
  assign rd_addr = rd_q[AW-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH)); // R3

  AST_RD_HOLD_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> $stable(rd_q)); // R6

  AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop_req) |=> $stable(wr_q)); // R3

endmodule

// File: rtl/txf_store.sv
module txf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 20,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] sample
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] sample_q, sample_d;

  // Storage array: no reset needed, entries are only read after a write.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Output holder: loads only on a real pop, so an underrun repeats it.
  always_comb begin
    sample_d = sample_q;
    if (rd_en) sample_d = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= '0;
    else if (rd_en) sample_q <= sample_d;
  end

  assign sample = sample_q;

  AST_SAMPLE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(sample_q)); // R5

endmodule

// File: rtl/txf_err_regs.sv
module txf_err_regs
  import txf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             underrun_evt,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);

  logic irq_en_q, irq_en_d;
  logic err_q, err_d;
  logic ctrl_wr, stat_clr;
  logic unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata[REG_W-1:ERR_FLAG_BIT+1], wdata[IRQ_EN_BIT-1:0]};

  always_comb begin
    ctrl_wr  = wr_en && (sel == SEL_CTRL);
    stat_clr = wr_en && (sel == SEL_STAT) && wdata[ERR_FLAG_BIT];
  end

  // Next-state: a new underrun outranks a clear in the same cycle.
  always_comb begin
    irq_en_d = ctrl_wr ? wdata[IRQ_EN_BIT] : irq_en_q;
    err_d    = err_q;
    if (stat_clr)     err_d = 1'b0;
    if (underrun_evt) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (ctrl_wr)                 irq_en_q <= irq_en_d;
      if (stat_clr || underrun_evt) err_q   <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_CTRL) rdata[IRQ_EN_BIT]   = irq_en_q;
    else                 rdata[ERR_FLAG_BIT] = err_q;
  end

  assign irq = irq_en_q && err_q;

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> err_q); // R8

  AST_ERR_CLEAR_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(stat_clr)); // R7

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[IRQ_EN_BIT]) |=> !irq); // R10

endmodule

// File: rtl/txf_underrun_fifo.sv
module txf_underrun_fifo
  import txf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 20,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             fifo_full,
  output logic             fifo_empty,
  input  logic             pop_req,
  output logic [WIDTH-1:0] sample_out,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);

  logic          rst_meta_q, rst_sync_q;
  logic          push_ok, pop_ok, underrun_evt;
  logic [AW-1:0] wr_addr, rd_addr;

  // Asynchronous assert, synchronous two-stage release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  txf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .push_valid   (push_valid),
    .pop_req      (pop_req),
    .push_ok      (push_ok),
    .pop_ok       (pop_ok),
    .underrun_evt (underrun_evt),
    .wr_addr      (wr_addr),
    .rd_addr      (rd_addr),
    .full         (fifo_full),
    .empty        (fifo_empty)
  );

  txf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (push_ok),
    .wr_addr (wr_addr),
    .wr_data (push_data),
    .rd_en   (pop_ok),
    .rd_addr (rd_addr),
    .sample  (sample_out)
  );

  txf_err_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .wr_en        (reg_wr),
    .sel          (reg_sel),
    .wdata        (reg_wdata),
    .underrun_evt (underrun_evt),
    .rdata        (reg_rdata),
    .irq          (irq)
  );

  AST_UNDERRUN_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pop_req && fifo_empty && reg_rdata[IRQ_EN_BIT] && reg_sel == SEL_CTRL) |=> irq); // R10

endmodule

// File: tb/test_txf_underrun_fifo.sv
module test_txf_underrun_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             push_valid, pop_req, reg_wr, reg_sel;
  logic [WIDTH-1:0] push_data, sample_out;
  logic [31:0]      reg_wdata, reg_rdata;
  logic             fifo_full, fifo_empty, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  txf_underrun_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_txf_underrun_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .pop_req(pop_req),
    .sample_out(sample_out), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [WIDTH-1:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
  endtask

  task automatic wr_reg(logic sel, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  function automatic logic [WIDTH-1:0] pat(int lvl, int i);
    return WIDTH'(lvl * 4099 + i * 37 + 1);
  endfunction

  initial begin
    logic [31:0] v;
    logic [WIDTH-1:0] last;
    rst_n = 1'b0; push_valid = 0; pop_req = 0; reg_wr = 0; reg_sel = 0;
    push_data = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(1'b1, v); chk("R1 status", v, 32'h0);
    rd_reg(1'b0, v); chk("R1 control", v, 32'h0);
    chk("R1 sample", 32'(sample_out), 32'h0);
    chk("R1 empty", 32'(fifo_empty), 32'h1);
    chk("R1 full", 32'(fifo_full), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R5: underrun before any pop repeats zero; R4 flag set; R10 masked
    pop();
    chk("R5 zero repeat", 32'(sample_out), 32'h0);
    rd_reg(1'b1, v); chk("R4 flag set", v, 32'h10);
    chk("R10 irq masked", 32'(irq), 32'h0);

    // R7 write zero keeps, write one clears
    wr_reg(1'b1, 32'hFFFF_FFEF);
    rd_reg(1'b1, v); chk("R7 write0 keeps", v, 32'h10);
    wr_reg(1'b1, 32'h0000_0010);
    rd_reg(1'b1, v); chk("R7 w1c clears", v, 32'h0);

    // R9 control writable bits
    wr_reg(1'b0, 32'hFFFF_FFF7);
    rd_reg(1'b0, v); chk("R9 other bits", v, 32'h0);
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, v); chk("R9 enable only", v, 32'h8);

    // Sweep all fill levels: R2 order, R5 repeat, R6 pointers, R10 irq
    for (int lvl = 1; lvl <= DEPTH; lvl++) begin
      for (int i = 0; i < lvl; i++) push(pat(lvl, i));
      for (int i = 0; i < lvl; i++) begin
        pop();
        chk(i == 0 ? "R6 fresh after underrun" : "R2 order",
            32'(sample_out), 32'(pat(lvl, i)));
      end
      last = pat(lvl, lvl - 1);
      pop();
      chk("R5 repeat last", 32'(sample_out), 32'(last));
      pop();
      chk("R5 repeat again", 32'(sample_out), 32'(last));
      chk("R10 irq on", 32'(irq), 32'h1);
      rd_reg(1'b1, v); chk("R11 status bits", v, 32'h10);
      if (lvl == 1) begin
        push(pat(99, 0));
        rd_reg(1'b1, v); chk("R6 flag stays", v, 32'h10);
        pop();
        chk("R6 push after underrun", 32'(sample_out), 32'(pat(99, 0)));
      end
      wr_reg(1'b1, 32'h10);
      chk("R10 irq falls", 32'(irq), 32'h0);
    end

    // R3 overfill
    for (int i = 0; i < DEPTH + 3; i++) push(pat(200, i));
    chk("R3 full", 32'(fifo_full), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(); chk("R3 kept oldest", 32'(sample_out), 32'(pat(200, i)));
    end
    chk("R3 empty after drain", 32'(fifo_empty), 32'h1);
    pop();
    chk("R3 excess dropped", 32'(sample_out), 32'(pat(200, DEPTH - 1)));
    rd_reg(1'b1, v); chk("R3 underrun after drain", v, 32'h10);
    wr_reg(1'b1, 32'h10);

    // R8 set wins over clear in same cycle
    @(negedge clk);
    pop_req = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h10;
    @(negedge clk);
    pop_req = 1'b0; reg_wr = 1'b0;
    rd_reg(1'b1, v); chk("R8 set wins", v, 32'h10);
    chk("R8 irq", 32'(irq), 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule